// File: doc/BRIEF.md
# Synchronous Burst SRAM Cycle Controller

This block is the control path of a single-cycle synchronous burst SRAM with a small on-block word array. Each rising clock edge classifies the inputs as one of five cycle types: deselect, start, next, hold, or sleep. A start loads the address from the external bus. A next cycle steps a two-bit burst counter in the low address bits. A hold cycle reuses the current address. The selected word is then either written, with byte masking, or marked for reading.

Two address strobes can open a cycle, and they do not have equal weight. The processor-side strobe always opens a read and takes priority over the controller-side strobe. The controller-side strobe opens a read or a write, as the write inputs choose. The output enable is combinational and never sampled. Data reaches the read port only in a selected read cycle while the output enable is low. A separate drive flag stands in for the tri-state buffer, and `rdata_o` reads zero whenever that flag is low.

Top module: `sburst_sram_ctl`

## Requirements
- R1: With the controller strobe low and chip enable A (active low) high, the cycle is a deselect. No write happens and `drive_o` is low in the following cycle.
- R2: A cycle opened by either strobe is a deselect when chip enable B (active high) is low or chip enable C (active low) is high. `drive_o` is then low.
- R3: While chip enable A is high, the processor strobe is ignored. With the controller strobe high, the edge acts as a next or hold cycle.
- R4: A processor-strobe start with the chip selected reads the external address. It stays a read even when the write inputs are active or the controller strobe is also low.
- R5: A controller-strobe start, with the processor strobe high and the chip selected, writes `wdata_i` to the external address when the write request is active. Otherwise it reads that address.
- R6: With both strobes high and a cycle open, advance low steps the two low address bits by one, wrapping 3 to 0, and leaves the upper bits unchanged. Advance high keeps the address.
- R7: The write request is active when `gw_n` is low, or when `bwe_n` is low and at least one `be_n` bit is low.
- R8: With `gw_n` high and `bwe_n` low, only the byte lanes whose `be_n` bit is low are written. Bit i selects bits 8i+7..8i. With `gw_n` low, all lanes are written.
- R9: A hold cycle with the write request active, directly after a processor-strobe read start, writes to that same address.
- R10: While `sleep_i` is high, every other input is ignored. No write takes place, the address and open-cycle state are kept, and `drive_o` is low.
- R11: `drive_o` equals (last edge was a selected read) AND NOT `oe_n` AND NOT `sleep_i`, with no clock in the path. `rdata_o` is zero while `drive_o` is low.
- R12: After reset, and after any deselect, next and hold cycles do nothing until a new start. With `rst_n` low, `drive_o` is low.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| sleep_i | input | 1 | Sleep, active high |
| cs_a_n | input | 1 | Chip enable A, active low |
| cs_b | input | 1 | Chip enable B, active high |
| cs_c_n | input | 1 | Chip enable C, active low |
| strb_cpu_n | input | 1 | Processor-side address strobe, active low |
| strb_ctl_n | input | 1 | Controller-side address strobe, active low |
| adv_n | input | 1 | Burst advance, active low |
| gw_n | input | 1 | Global write, active low |
| bwe_n | input | 1 | Byte-write enable, active low |
| be_n | input | DW/8 | Byte lane enables, active low |
| oe_n | input | 1 | Asynchronous output enable, active low |
| addr_i | input | AW | External address |
| wdata_i | input | DW | Write data |
| rdata_o | output | DW | Read data, zero when not driven |
| drive_o | output | 1 | Output drivers enabled |

## Verification
A single edge can carry both an address start and a write that is not allowed to happen. Examples are a processor strobe with global write low, both strobes low together, and a controller strobe while sleep or a deselecting enable is present. The bench sets up each of these situations. It then reads the target word back in a later read cycle and checks that the data is unchanged and that the cycle type is correct. It also writes on the very address a read has just opened, and toggles the output enable between edges to confirm that the output follows it without waiting for a clock.

// File: rtl/sbs_pkg.sv
package sbs_pkg;
  typedef enum logic [1:0] {
    CYC_IDLE  = 2'd0,
    CYC_START = 2'd1,
    CYC_NEXT  = 2'd2,
    CYC_HOLD  = 2'd3
  } cyc_e;
endpackage

// File: rtl/sbs_decode.sv
module sbs_decode
  import sbs_pkg::*;
#(
  parameter int NB = 4
) (
  input  logic          sleep_i,
  input  logic          cs_a_n,
  input  logic          cs_b,
  input  logic          cs_c_n,
  input  logic          strb_cpu_n,
  input  logic          strb_ctl_n,
  input  logic          adv_n,
  input  logic          gw_n,
  input  logic          bwe_n,
  input  logic [NB-1:0] be_n,
  input  logic          open_q,
  output cyc_e          cyc,
  output logic          desel,
  output logic          rd_cyc,
  output logic [NB-1:0] lane_we
);
  logic cpu_go, ctl_go, chip_ok, wr_req, wr_cyc;

  // a processor strobe only counts while enable A is asserted
  assign cpu_go  = !strb_cpu_n && !cs_a_n;
  assign ctl_go  = !strb_ctl_n;
  assign chip_ok = !cs_a_n && cs_b && !cs_c_n;
  assign wr_req  = !gw_n || (!bwe_n && !(&be_n));

  always_comb begin
    cyc    = CYC_IDLE;
    desel  = 1'b0;
    wr_cyc = 1'b0;
    if (sleep_i) begin
      cyc = CYC_IDLE;
    end else if (cpu_go || ctl_go) begin
      if (!chip_ok) begin
        desel = 1'b1;
      end else begin
        cyc    = CYC_START;
        wr_cyc = !cpu_go && wr_req;
      end
    end else if (open_q) begin
      cyc    = adv_n ? CYC_HOLD : CYC_NEXT;
      wr_cyc = wr_req;
    end
  end

  assign rd_cyc = (cyc != CYC_IDLE) && !wr_cyc;

  always_comb begin
    if (!wr_cyc)    lane_we = '0;
    else if (!gw_n) lane_we = '1;
    else            lane_we = bwe_n ? '0 : ~be_n;
  end
endmodule

// File: rtl/sbs_burst.sv
module sbs_burst
  import sbs_pkg::*;
#(
  parameter int AW = 4,
  parameter int BB = 2
) (
  input  logic          clk,
  input  logic          rst_n,
  input  cyc_e          cyc,
  input  logic [AW-1:0] ext_addr,
  output logic [AW-1:0] addr_use,
  output logic [AW-1:0] addr_q
);
  logic [BB-1:0] lo_step;
  logic          addr_en;

  assign lo_step = addr_q[BB-1:0] + 1'b1;

  always_comb begin
    case (cyc)
      CYC_START: addr_use = ext_addr;
      CYC_NEXT:  addr_use = {addr_q[AW-1:BB], lo_step};
      default:   addr_use = addr_q;
    endcase
  end

  assign addr_en = (cyc != CYC_IDLE);

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n)       addr_q <= '0;
    else if (addr_en) addr_q <= addr_use;
  end
endmodule

// File: rtl/sbs_array.sv
module sbs_array #(
  parameter int DW = 32,
  parameter int AW = 4
) (
  input  logic              clk,
  input  logic [DW/8-1:0]   lane_we,
  input  logic [AW-1:0]     waddr,
  input  logic [DW-1:0]     wdata,
  input  logic [AW-1:0]     raddr,
  output logic [DW-1:0]     rdata
);
  localparam int NB    = DW / 8;
  localparam int DEPTH = 1 << AW;

  for (genvar g = 0; g < NB; g++) begin : g_lane
    logic [7:0] mem [DEPTH];
    always_ff @(posedge clk) begin
      if (lane_we[g]) mem[waddr] <= wdata[8*g +: 8];
    end
    assign rdata[8*g +: 8] = mem[raddr];
  end
endmodule

// File: rtl/sburst_sram_ctl.sv
module sburst_sram_ctl
  import sbs_pkg::*;
#(
  parameter int DW = 32,
  parameter int AW = 4,
  parameter int BB = 2
) (
  input  logic            clk,
  input  logic            rst_n,
  input  logic            sleep_i,
  input  logic            cs_a_n,
  input  logic            cs_b,
  input  logic            cs_c_n,
  input  logic            strb_cpu_n,
  input  logic            strb_ctl_n,
  input  logic            adv_n,
  input  logic            gw_n,
  input  logic            bwe_n,
  input  logic [DW/8-1:0] be_n,
  input  logic            oe_n,
  input  logic [AW-1:0]   addr_i,
  input  logic [DW-1:0]   wdata_i,
  output logic [DW-1:0]   rdata_o,
  output logic            drive_o
);
  localparam int NB = DW / 8;

  cyc_e          cyc;
  logic          desel, rd_cyc;
  logic [NB-1:0] lane_we;
  logic [AW-1:0] addr_use, addr_q;
  logic [DW-1:0] arr_rd;
  logic          open_q, open_d, rd_q, rd_d;

  sbs_decode #(.NB(NB)) u_dec (
    .sleep_i(sleep_i), .cs_a_n(cs_a_n), .cs_b(cs_b), .cs_c_n(cs_c_n),
    .strb_cpu_n(strb_cpu_n), .strb_ctl_n(strb_ctl_n), .adv_n(adv_n),
    .gw_n(gw_n), .bwe_n(bwe_n), .be_n(be_n), .open_q(open_q),
    .cyc(cyc), .desel(desel), .rd_cyc(rd_cyc), .lane_we(lane_we)
  );

  sbs_burst #(.AW(AW), .BB(BB)) u_bst (
    .clk(clk), .rst_n(rst_n), .cyc(cyc), .ext_addr(addr_i),
    .addr_use(addr_use), .addr_q(addr_q)
  );

  sbs_array #(.DW(DW), .AW(AW)) u_arr (
    .clk(clk), .lane_we(lane_we), .waddr(addr_use), .wdata(wdata_i),
    .raddr(addr_q), .rdata(arr_rd)
  );

  // next state: sleep freezes the open flag, a deselect closes it
  always_comb begin
    open_d = open_q;
    if (desel)                 open_d = 1'b0;
    else if (cyc == CYC_START) open_d = 1'b1;
    rd_d = rd_cyc;
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      open_q <= 1'b0;
      rd_q   <= 1'b0;
    end else begin
      open_q <= open_d;
      rd_q   <= rd_d;
    end
  end

  assign drive_o = rd_q && !oe_n && !sleep_i;
  assign rdata_o = drive_o ? arr_rd : '0;
endmodule

// File: rtl/sbs_chk.sv
module sbs_chk #(
  parameter int DW = 32
) (
  input logic            clk,
  input logic            rst_n,
  input logic            sleep_i,
  input logic            cs_a_n,
  input logic            cs_b,
  input logic            cs_c_n,
  input logic            strb_cpu_n,
  input logic            strb_ctl_n,
  input logic            gw_n,
  input logic            bwe_n,
  input logic [DW/8-1:0] be_n,
  input logic            oe_n,
  input logic [DW-1:0]   rdata_o,
  input logic            drive_o
);
  logic sel_ok, wr_req;
  assign sel_ok = !cs_a_n && cs_b && !cs_c_n;
  assign wr_req = !gw_n || (!bwe_n && !(&be_n));

  p_desel_a_r1: assert property (@(posedge clk) disable iff (!rst_n)
    (!sleep_i && !strb_ctl_n && cs_a_n) |=> !drive_o);

  p_desel_bc_r2: assert property (@(posedge clk) disable iff (!rst_n)
    (!sleep_i && (!strb_ctl_n || (!strb_cpu_n && !cs_a_n)) && (!cs_b || cs_c_n))
      |=> !drive_o);

  p_cpu_read_r4: assert property (@(posedge clk) disable iff (!rst_n)
    (!sleep_i && !strb_cpu_n && sel_ok) |=> (oe_n || sleep_i || drive_o));

  p_ctl_write_r5: assert property (@(posedge clk) disable iff (!rst_n)
    (!sleep_i && strb_cpu_n && !strb_ctl_n && sel_ok && wr_req) |=> !drive_o);

  p_sleep_quiet_r10: assert property (@(posedge clk) disable iff (!rst_n)
    sleep_i |-> !drive_o);

  p_oe_mask_r11: assert property (@(posedge clk) disable iff (!rst_n)
    oe_n |-> (!drive_o && rdata_o == '0));
endmodule

bind sburst_sram_ctl sbs_chk #(.DW(DW)) u_chk (
  .clk(clk), .rst_n(rst_n), .sleep_i(sleep_i), .cs_a_n(cs_a_n), .cs_b(cs_b),
  .cs_c_n(cs_c_n), .strb_cpu_n(strb_cpu_n), .strb_ctl_n(strb_ctl_n),
  .gw_n(gw_n), .bwe_n(bwe_n), .be_n(be_n), .oe_n(oe_n),
  .rdata_o(rdata_o), .drive_o(drive_o)
);

// File: tb/sburst_sram_ctl_bench.sv
module sburst_sram_ctl_bench;
  logic        clk = 1'b0;
  logic        rst_n;
  logic        sleep_i, cs_a_n, cs_b, cs_c_n, strb_cpu_n, strb_ctl_n, adv_n;
  logic        gw_n, bwe_n, oe_n;
  logic [3:0]  be_n, addr_i;
  logic [31:0] wdata_i, rdata_o;
  logic        drive_o;
  int          n_chk = 0;
  int          n_err = 0;
  bit          done  = 1'b0;

  always #10 clk = ~clk;

  sburst_sram_ctl u_sburst_sram_ctl (
    .clk(clk), .rst_n(rst_n), .sleep_i(sleep_i), .cs_a_n(cs_a_n), .cs_b(cs_b),
    .cs_c_n(cs_c_n), .strb_cpu_n(strb_cpu_n), .strb_ctl_n(strb_ctl_n),
    .adv_n(adv_n), .gw_n(gw_n), .bwe_n(bwe_n), .be_n(be_n), .oe_n(oe_n),
    .addr_i(addr_i), .wdata_i(wdata_i), .rdata_o(rdata_o), .drive_o(drive_o)
  );

  typedef struct packed {
    logic slp, c1n, c2, c3n, cpn, ctn, avn, gwn, bwn;
    logic [3:0]  ben;
    logic        oen;
    logic [3:0]  adr;
    logic [31:0] wd;
    logic        edrv;
    logic [31:0] erd;
    logic [7:0]  req;
  } vec_t;

  localparam int NV = 28;
  localparam vec_t TBL [NV] = '{
    // slp c1n c2 c3n cpn ctn avn gwn bwn ben oen adr wd edrv erd req
    '{1'b0,1'b0,1'b1,1'b0,1'b1,1'b0,1'b1,1'b0,1'b1,4'hF,1'b0,4'd4,32'hA0A00001,1'b0,32'h0,8'd5},        // R5 write 4
    '{1'b0,1'b0,1'b1,1'b0,1'b1,1'b1,1'b0,1'b0,1'b1,4'hF,1'b0,4'd0,32'hB0B00002,1'b0,32'h0,8'd6},        // R6 next 5
    '{1'b0,1'b0,1'b1,1'b0,1'b1,1'b1,1'b0,1'b0,1'b1,4'hF,1'b0,4'd0,32'hC0C00003,1'b0,32'h0,8'd6},        // R6 next 6
    '{1'b0,1'b0,1'b1,1'b0,1'b1,1'b1,1'b0,1'b0,1'b1,4'hF,1'b0,4'd0,32'hD0D00004,1'b0,32'h0,8'd6},        // R6 next 7
    '{1'b0,1'b0,1'b1,1'b0,1'b1,1'b1,1'b0,1'b1,1'b1,4'hF,1'b0,4'd0,32'h0,1'b1,32'hA0A00001,8'd6},        // R6 wrap to 4
    '{1'b0,1'b0,1'b1,1'b0,1'b1,1'b1,1'b1,1'b1,1'b1,4'hF,1'b0,4'd0,32'h0,1'b1,32'hA0A00001,8'd6},        // R6 hold
    '{1'b0,1'b0,1'b1,1'b0,1'b1,1'b1,1'b0,1'b1,1'b1,4'hF,1'b1,4'd0,32'h0,1'b0,32'h0,8'd11},              // R11 oe high
    '{1'b0,1'b0,1'b1,1'b0,1'b1,1'b1,1'b1,1'b1,1'b1,4'hF,1'b0,4'd0,32'h0,1'b1,32'hB0B00002,8'd11},       // R11 oe low
    '{1'b0,1'b0,1'b1,1'b0,1'b0,1'b1,1'b1,1'b0,1'b1,4'hF,1'b0,4'd6,32'hDEAD0000,1'b1,32'hC0C00003,8'd4}, // R4 forced read
    '{1'b0,1'b0,1'b1,1'b0,1'b1,1'b1,1'b1,1'b1,1'b0,4'hE,1'b0,4'd0,32'h11223344,1'b0,32'h0,8'd9},        // R9 write same addr
    '{1'b0,1'b0,1'b1,1'b0,1'b1,1'b1,1'b1,1'b1,1'b1,4'hF,1'b0,4'd0,32'h0,1'b1,32'hC0C00044,8'd8},        // R8 lane 0 only
    '{1'b0,1'b0,1'b1,1'b0,1'b1,1'b0,1'b1,1'b1,1'b0,4'hF,1'b0,4'd7,32'h00000BAD,1'b1,32'hD0D00004,8'd7}, // R7 bwe, no lane
    '{1'b0,1'b0,1'b1,1'b0,1'b1,1'b0,1'b1,1'b1,1'b1,4'h0,1'b0,4'd5,32'h00000BAD,1'b1,32'hB0B00002,8'd7}, // R7 lanes, bwe high
    '{1'b0,1'b1,1'b1,1'b0,1'b1,1'b0,1'b1,1'b0,1'b1,4'hF,1'b0,4'd5,32'hFFFFFFFF,1'b0,32'h0,8'd1},        // R1 deselect
    '{1'b0,1'b0,1'b1,1'b0,1'b1,1'b1,1'b0,1'b1,1'b1,4'hF,1'b0,4'd0,32'h0,1'b0,32'h0,8'd12},              // R12 closed
    '{1'b0,1'b0,1'b0,1'b0,1'b0,1'b1,1'b1,1'b1,1'b1,4'hF,1'b0,4'd5,32'h0,1'b0,32'h0,8'd2},               // R2 B low
    '{1'b0,1'b0,1'b1,1'b1,1'b0,1'b1,1'b1,1'b1,1'b1,4'hF,1'b0,4'd5,32'h0,1'b0,32'h0,8'd2},               // R2 C high
    '{1'b0,1'b0,1'b1,1'b0,1'b0,1'b1,1'b1,1'b1,1'b1,4'hF,1'b0,4'd5,32'h0,1'b1,32'hB0B00002,8'd1},        // R1 no write
    '{1'b0,1'b1,1'b1,1'b0,1'b0,1'b1,1'b0,1'b1,1'b1,4'hF,1'b0,4'd0,32'h0,1'b1,32'hC0C00044,8'd3},        // R3 next
    '{1'b1,1'b0,1'b1,1'b0,1'b1,1'b0,1'b1,1'b0,1'b1,4'hF,1'b0,4'd4,32'h0,1'b0,32'h0,8'd10},              // R10 sleep
    '{1'b0,1'b0,1'b1,1'b0,1'b1,1'b1,1'b1,1'b1,1'b1,4'hF,1'b0,4'd0,32'h0,1'b1,32'hC0C00044,8'd10},       // R10 kept
    '{1'b0,1'b0,1'b1,1'b0,1'b0,1'b1,1'b1,1'b1,1'b1,4'hF,1'b0,4'd4,32'h0,1'b1,32'hA0A00001,8'd10},       // R10 no write
    '{1'b0,1'b0,1'b1,1'b0,1'b1,1'b0,1'b1,1'b0,1'b1,4'hF,1'b0,4'd12,32'h01020304,1'b0,32'h0,8'd5},       // R5 write 12
    '{1'b0,1'b0,1'b1,1'b0,1'b1,1'b1,1'b1,1'b1,1'b0,4'h5,1'b0,4'd0,32'hAABBCCDD,1'b0,32'h0,8'd8},        // R8 lanes 1,3
    '{1'b0,1'b0,1'b1,1'b0,1'b1,1'b1,1'b1,1'b1,1'b1,4'hF,1'b0,4'd0,32'h0,1'b1,32'hAA02CC04,8'd8},        // R8 readback
    '{1'b0,1'b0,1'b1,1'b0,1'b1,1'b1,1'b1,1'b0,1'b0,4'hF,1'b0,4'd0,32'h0F0F0F0F,1'b0,32'h0,8'd7},        // R7 gw over
    '{1'b0,1'b0,1'b1,1'b0,1'b1,1'b1,1'b1,1'b1,1'b1,4'hF,1'b0,4'd0,32'h0,1'b1,32'h0F0F0F0F,8'd7},        // R7 readback
    '{1'b0,1'b0,1'b1,1'b0,1'b0,1'b0,1'b1,1'b0,1'b1,4'hF,1'b0,4'd12,32'h0,1'b1,32'h0F0F0F0F,8'd4}        // R4 both strobes
  };

  task automatic check(input int req, input logic [31:0] act, input logic [31:0] exp);
    n_chk++;
    if (act !== exp) begin
      n_err++;
      $display("FAIL R%0d: actual=%h expected=%h at %0t", req, act, exp, $time);
    end
  endtask

  task automatic idle();
    sleep_i = 1'b0; cs_a_n = 1'b0; cs_b = 1'b1; cs_c_n = 1'b0;
    strb_cpu_n = 1'b1; strb_ctl_n = 1'b1; adv_n = 1'b1;
    gw_n = 1'b1; bwe_n = 1'b1; be_n = 4'hF; oe_n = 1'b0;
    addr_i = '0; wdata_i = '0;
  endtask

  task automatic finish_run();
    $display("Result: errors=%0d of %0d checks", n_err, n_chk);
    $finish;
  endtask

  initial begin
    for (int c = 0; c < 5000; c++) @(posedge clk);
    if (!done) begin
      n_chk++; n_err++;
      $display("FAIL watchdog: actual=hung expected=done");
      finish_run();
    end
  end

  initial begin
    idle();
    rst_n = 1'b0;
    repeat (3) @(posedge clk);
    #5;
    check(12, {31'd0, drive_o}, 32'd0);   // R12 reset state
    check(12, rdata_o, 32'd0);
    @(negedge clk) rst_n = 1'b1;
    @(negedge clk) adv_n = 1'b0;           // next cycle with nothing open
    @(posedge clk); #5;
    check(12, {31'd0, drive_o}, 32'd0);    // R12 no cycle after reset

    for (int i = 0; i < NV; i++) begin
      @(negedge clk);
      sleep_i = TBL[i].slp; cs_a_n = TBL[i].c1n; cs_b = TBL[i].c2;
      cs_c_n = TBL[i].c3n; strb_cpu_n = TBL[i].cpn; strb_ctl_n = TBL[i].ctn;
      adv_n = TBL[i].avn; gw_n = TBL[i].gwn; bwe_n = TBL[i].bwn;
      be_n = TBL[i].ben; oe_n = TBL[i].oen; addr_i = TBL[i].adr;
      wdata_i = TBL[i].wd;
      @(posedge clk); #5;
      check(int'(TBL[i].req), {31'd0, drive_o}, {31'd0, TBL[i].edrv});
      check(int'(TBL[i].req), rdata_o, TBL[i].erd);
    end

    // R11: output enable acts between edges; the state is a read of 12
    @(negedge clk) idle();
    #2 oe_n = 1'b1; #1;
    check(11, {31'd0, drive_o}, 32'd0);
    check(11, rdata_o, 32'd0);
    #2 oe_n = 1'b0; #1;
    check(11, {31'd0, drive_o}, 32'd1);
    check(11, rdata_o, 32'h0F0F0F0F);
    // R10: sleep removes drive without a clock
    #1 sleep_i = 1'b1; #1;
    check(10, {31'd0, drive_o}, 32'd0);
    sleep_i = 1'b0;
    // R12: reset is asynchronous
    #1 rst_n = 1'b0; #1;
    check(12, {31'd0, drive_o}, 32'd0);
    done = 1'b1;
    finish_run();
  end
endmodule